// File: doc/BRIEF.md
# Hardware Exception Entry Unit

This unit applies the architectural state changes that a small 32-bit soft processor makes when it takes a hardware exception. It sits in the state-update path as one registered stage. In a cycle with no exception, the program counter, machine status word and the two pipeline flags (delay slot and immediate prefix) pass through with one cycle of latency. When a raise is accepted, the same registers take their exception-entry values instead.

An accepted raise does all of its work on one clock edge. The unit produces a link value of PC plus four, with a write strobe, for general register 17. It rewrites the exception status word with the cause code and a delay-slot marker. If the faulting instruction sat in a branch delay slot, it captures the pending branch target. It moves the live translation and user-mode bits into their saved copies, clears the live bits and sets the exception-in-progress bit. The program counter goes to a fixed vector. If the configuration input reports that exceptions are not implemented, a raise is dropped and the status, branch-target and link registers do not change.

Top module: `exc_entry_unit`

## Requirements
- R1: While `rst` is high, and on the first clock after it, every output register is zero, including `taken_o` and `link_we_o`.
- R2: When `exc_en_i` is 0, a raise is ignored. `taken_o` and `link_we_o` stay 0, `esr_o`, `btr_o` and `link_o` keep their values, and `pc_o`, `msr_o`, `dslot_o` and `imm_o` show the pass-through values.
- R3: One clock after an accepted raise, `taken_o` and `link_we_o` are 1 for exactly one cycle, and `link_o` equals the raised `pc_i` plus 4.
- R4: On entry, `esr_o` bits [4:0] hold the cause code and every other bit is zero except bit 12. The cause codes are: stream link 0, unaligned data 1, illegal opcode 2, instruction bus 3, data bus 4, divide by zero 5, floating point 6, privileged 7, data storage 8, instruction storage 9, data TLB miss 10, instruction TLB miss 11.
- R5: On entry, `esr_o` bit 12 equals `dslot_i`. When `dslot_i` is 1, `btr_o` is loaded with `btarget_i`. When `dslot_i` is 0, `btr_o` keeps its previous value.
- R6: On entry, the status word takes these values: bit 12 (saved user mode) gets input bit 11 (user mode), bit 14 (saved translation) gets input bit 13 (translation), bits 11 and 13 are cleared, and every bit other than 9, 11, 12, 13 and 14 is copied unchanged.
- R7: On entry, status bit 9 (exception in progress) is set.
- R8: On entry, `pc_o` becomes the vector 0x20.
- R9: On entry, `dslot_o` and `imm_o` are cleared.
- R10: In a cycle without an accepted raise, `pc_o`, `msr_o`, `dslot_o` and `imm_o` show the previous cycle's `pc_i`, `msr_i`, `dslot_i` and `imm_i`.
- R11: A raise that arrives while input status bit 9 is already set is still accepted, and it overwrites the status, link and branch-target state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_en_i | input | 1 | Configuration: hardware exceptions implemented |
| raise_i | input | 1 | Exception raise strobe |
| cause_i | input | 5 | Exception cause code |
| pc_i | input | 32 | Current program counter |
| btarget_i | input | 32 | Pending branch target |
| dslot_i | input | 1 | Current instruction is in a delay slot |
| imm_i | input | 1 | Immediate-prefix flag |
| msr_i | input | 32 | Current machine status word |
| pc_o | output | 32 | Next program counter |
| msr_o | output | 32 | Next machine status word |
| dslot_o | output | 1 | Next delay-slot flag |
| imm_o | output | 1 | Next immediate-prefix flag |
| esr_o | output | 32 | Exception status register |
| btr_o | output | 32 | Branch target register |
| link_o | output | 32 | Return address for register 17 |
| link_we_o | output | 1 | Write strobe for register 17 |
| taken_o | output | 1 | Exception entry occurred on the last edge |

## Verification
The bench uses the default parameters: a 32-bit word, vector 0x20 and link offset 4. At this size it can raise every defined cause code with the delay-slot flag both clear and set, and cross each case with all four combinations of the live translation and user-mode bits. That covers every bit move in the status word and both paths of the branch-target register. The bench also runs ignored raises, pass-through cycles and a raise while the exception-in-progress bit is already set, and checks each against an arithmetic model.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CAUSE_W = 5;
  localparam int ESR_DS_BIT = 12;
  localparam int MSR_EIP = 9;
  localparam int MSR_UM = 11;
  localparam int MSR_VM = 13;
  localparam int N_SAVED = 2;
  // live mode bits; each saved copy sits one position higher
  localparam int LIVE_POS [N_SAVED] = '{MSR_UM, MSR_VM};

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_STREAM      = 5'd0,
    CAUSE_UNALIGNED   = 5'd1,
    CAUSE_ILLEGAL     = 5'd2,
    CAUSE_IBUS        = 5'd3,
    CAUSE_DBUS        = 5'd4,
    CAUSE_DIVZERO     = 5'd5,
    CAUSE_FLOAT       = 5'd6,
    CAUSE_PRIV        = 5'd7,
    CAUSE_DSTORAGE    = 5'd8,
    CAUSE_ISTORAGE    = 5'd9,
    CAUSE_DTLB        = 5'd10,
    CAUSE_ITLB        = 5'd11
  } exc_cause_e;
endpackage

// File: rtl/exc_msr_update.sv
module exc_msr_update #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] msr_i,
  output logic [XLEN-1:0] msr_o
);
  import exc_pkg::*;

  always_comb begin
    msr_o = msr_i;
    for (int k = 0; k < N_SAVED; k++) begin
      msr_o[LIVE_POS[k] + 1] = msr_i[LIVE_POS[k]];  // R6 save copy
      msr_o[LIVE_POS[k]]     = 1'b0;                // R6 clear live bit
    end
    msr_o[MSR_EIP] = 1'b1;                          // R7
  end
endmodule

// File: rtl/exc_status_calc.sv
module exc_status_calc #(
  parameter int XLEN = 32
) (
  input  logic [exc_pkg::CAUSE_W-1:0] cause_i,
  input  logic                        dslot_i,
  output logic [XLEN-1:0]             esr_o
);
  import exc_pkg::*;

  localparam int PAD_W = XLEN - CAUSE_W;

  always_comb begin
    esr_o = {{PAD_W{1'b0}}, cause_i};   // R4
    esr_o[ESR_DS_BIT] = dslot_i;        // R5
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit #(
  parameter int          XLEN     = 32,
  parameter logic [31:0] VECTOR   = 32'h0000_0020,
  parameter int          LINK_OFS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        exc_en_i,
  input  logic                        raise_i,
  input  logic [exc_pkg::CAUSE_W-1:0] cause_i,
  input  logic [XLEN-1:0]             pc_i,
  input  logic [XLEN-1:0]             btarget_i,
  input  logic                        dslot_i,
  input  logic                        imm_i,
  input  logic [XLEN-1:0]             msr_i,
  output logic [XLEN-1:0]             pc_o,
  output logic [XLEN-1:0]             msr_o,
  output logic                        dslot_o,
  output logic                        imm_o,
  output logic [XLEN-1:0]             esr_o,
  output logic [XLEN-1:0]             btr_o,
  output logic [XLEN-1:0]             link_o,
  output logic                        link_we_o,
  output logic                        taken_o
);
  localparam logic [XLEN-1:0] VEC_W = XLEN'(VECTOR);
  localparam logic [XLEN-1:0] OFS_W = XLEN'(LINK_OFS);

  logic            take;
  logic [XLEN-1:0] msr_entry;
  logic [XLEN-1:0] esr_entry;

  assign take = raise_i & exc_en_i;  // R2 gate on configuration

  exc_msr_update #(.XLEN(XLEN)) u_msr (
    .msr_i (msr_i),
    .msr_o (msr_entry)
  );

  exc_status_calc #(.XLEN(XLEN)) u_esr (
    .cause_i (cause_i),
    .dslot_i (dslot_i),
    .esr_o   (esr_entry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o      <= '0;
      msr_o     <= '0;
      dslot_o   <= 1'b0;
      imm_o     <= 1'b0;
      esr_o     <= '0;
      btr_o     <= '0;
      link_o    <= '0;
      link_we_o <= 1'b0;
      taken_o   <= 1'b0;
    end else begin
      taken_o   <= take;
      link_we_o <= take;
      if (take) begin
        pc_o    <= VEC_W;              // R8
        msr_o   <= msr_entry;          // R6 R7
        dslot_o <= 1'b0;               // R9
        imm_o   <= 1'b0;
        esr_o   <= esr_entry;          // R4
        link_o  <= pc_i + OFS_W;       // R3
        if (dslot_i) btr_o <= btarget_i;  // R5
      end else begin
        pc_o    <= pc_i;               // R10
        msr_o   <= msr_i;
        dslot_o <= dslot_i;
        imm_o   <= imm_i;
      end
    end
  end
endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker #(
  parameter int          XLEN     = 32,
  parameter logic [31:0] VECTOR   = 32'h0000_0020,
  parameter int          LINK_OFS = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            exc_en_i,
  input logic            raise_i,
  input logic [4:0]      cause_i,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] btarget_i,
  input logic            dslot_i,
  input logic [XLEN-1:0] msr_i,
  input logic [XLEN-1:0] pc_o,
  input logic [XLEN-1:0] msr_o,
  input logic            dslot_o,
  input logic            imm_o,
  input logic [XLEN-1:0] esr_o,
  input logic [XLEN-1:0] btr_o,
  input logic [XLEN-1:0] link_o,
  input logic            link_we_o,
  input logic            taken_o
);
  AST_IGNORED_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
    !exc_en_i |=> !taken_o && !link_we_o && $stable(esr_o) && $stable(btr_o)); // R2
  AST_LINK_ADDR: assert property (@(posedge clk) disable iff (rst)
    (raise_i && exc_en_i) |=> link_we_o && link_o == $past(pc_i) + XLEN'(LINK_OFS)); // R3
  AST_CAUSE_RECORD: assert property (@(posedge clk) disable iff (rst)
    (raise_i && exc_en_i) |=> esr_o[4:0] == $past(cause_i)); // R4
  AST_DSLOT_BTR: assert property (@(posedge clk) disable iff (rst)
    (raise_i && exc_en_i && dslot_i) |=> esr_o[12] && btr_o == $past(btarget_i)); // R5
  AST_MODE_SAVE: assert property (@(posedge clk) disable iff (rst)
    (raise_i && exc_en_i) |=> !msr_o[11] && !msr_o[13]
      && msr_o[12] == $past(msr_i[11]) && msr_o[14] == $past(msr_i[13])); // R6
  AST_EIP_SET: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> msr_o[9]); // R7
  AST_VECTOR_PC: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> pc_o == XLEN'(VECTOR)); // R8
  AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> !dslot_o && !imm_o); // R9
endmodule

bind exc_entry_unit exc_entry_checker #(
  .XLEN(XLEN), .VECTOR(VECTOR), .LINK_OFS(LINK_OFS)
) u_chk (
  .clk(clk), .rst(rst), .exc_en_i(exc_en_i), .raise_i(raise_i),
  .cause_i(cause_i), .pc_i(pc_i), .btarget_i(btarget_i), .dslot_i(dslot_i),
  .msr_i(msr_i), .pc_o(pc_o), .msr_o(msr_o), .dslot_o(dslot_o), .imm_o(imm_o),
  .esr_o(esr_o), .btr_o(btr_o), .link_o(link_o), .link_we_o(link_we_o),
  .taken_o(taken_o)
);

// File: tb/exc_entry_unit_test.sv
module exc_entry_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exc_en_i = 1'b1;
  logic        raise_i = 1'b0;
  logic [4:0]  cause_i = '0;
  logic [31:0] pc_i = '0;
  logic [31:0] btarget_i = '0;
  logic        dslot_i = 1'b0;
  logic        imm_i = 1'b0;
  logic [31:0] msr_i = '0;
  logic [31:0] pc_o, msr_o, esr_o, btr_o, link_o;
  logic        dslot_o, imm_o, link_we_o, taken_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [31:0] exp_esr = '0;
  logic [31:0] exp_btr = '0;
  logic [31:0] exp_link = '0;

  exc_entry_unit uut (
    .clk(clk), .rst(rst), .exc_en_i(exc_en_i), .raise_i(raise_i),
    .cause_i(cause_i), .pc_i(pc_i), .btarget_i(btarget_i), .dslot_i(dslot_i),
    .imm_i(imm_i), .msr_i(msr_i), .pc_o(pc_o), .msr_o(msr_o),
    .dslot_o(dslot_o), .imm_o(imm_o), .esr_o(esr_o), .btr_o(btr_o),
    .link_o(link_o), .link_we_o(link_we_o), .taken_o(taken_o)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] entry_msr(input logic [31:0] m);
    logic [31:0] e = m;
    e[12] = m[11];
    e[14] = m[13];
    e[11] = 1'b0;
    e[13] = 1'b0;
    e[9]  = 1'b1;
    return e;
  endfunction

  task automatic raise_once(input int c, input bit ds, input bit im,
                            input logic [31:0] m, input logic [31:0] p,
                            input logic [31:0] bt);
    @(negedge clk);
    exc_en_i = 1'b1; raise_i = 1'b1; cause_i = 5'(c); dslot_i = ds;
    imm_i = im; msr_i = m; pc_i = p; btarget_i = bt;
    @(negedge clk);
    raise_i = 1'b0;
    exp_esr = 32'(c);
    exp_esr[12] = ds;
    if (ds) exp_btr = bt;
    exp_link = p + 32'd4;
    chk("R3 taken", {31'd0, taken_o}, 32'd1);
    chk("R3 link_we", {31'd0, link_we_o}, 32'd1);
    chk("R3 link", link_o, exp_link);
    chk("R4 esr", esr_o, exp_esr);
    chk("R5 btr", btr_o, exp_btr);
    chk("R6 msr", msr_o & ~32'h200, entry_msr(m) & ~32'h200);
    chk("R7 eip", {31'd0, msr_o[9]}, 32'd1);
    chk("R8 pc", pc_o, 32'h20);
    chk("R9 flags", {30'd0, dslot_o, imm_o}, 32'd0);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pc", pc_o, 32'd0);
    chk("R1 msr", msr_o, 32'd0);
    chk("R1 esr", esr_o, 32'd0);
    chk("R1 btr", btr_o, 32'd0);
    chk("R1 strobes", {30'd0, taken_o, link_we_o}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 first clock", {30'd0, taken_o, link_we_o}, 32'd0);

    // sweep all causes, delay-slot on/off, all VM/UM combinations
    for (int c = 0; c < 12; c++) begin
      for (int ds = 0; ds < 2; ds++) begin
        for (int v = 0; v < 4; v++) begin
          logic [31:0] m;
          m = 32'h5A5A_0000 | 32'(c * 32'h111);
          m[9] = 1'b0; m[11] = v[0]; m[13] = v[1];
          m[12] = ~v[0]; m[14] = ~v[1];
          raise_once(c, ds[0], v[0] ^ ds[0], m, 32'h1000 + 32'(c * 64 + v * 4),
                     32'h8000_0000 | 32'(c << 8) | 32'(v << 4) | 32'(ds));
          // R10 pass-through on the following cycle; R3 single pulse
          pc_i = 32'hCAFE_0000 | 32'(c); msr_i = m ^ 32'hFFFF; dslot_i = 1'b1; imm_i = 1'b1;
          @(negedge clk);
          chk("R3 pulse ends", {30'd0, taken_o, link_we_o}, 32'd0);
          chk("R10 pc", pc_o, 32'hCAFE_0000 | 32'(c));
          chk("R10 msr", msr_o, m ^ 32'hFFFF);
          chk("R10 flags", {30'd0, dslot_o, imm_o}, 32'd3);
          chk("R5 btr hold", btr_o, exp_btr);
        end
      end
    end

    // R2 ignored raises when exceptions are not configured
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      exc_en_i = 1'b0; raise_i = 1'b1; cause_i = 5'(11 - c); dslot_i = 1'b1;
      imm_i = c[0]; pc_i = 32'h7700 + 32'(c); btarget_i = 32'hDEAD_0000 | 32'(c);
      msr_i = 32'h0000_2800 | 32'(c);
      @(negedge clk);
      chk("R2 no take", {30'd0, taken_o, link_we_o}, 32'd0);
      chk("R2 esr held", esr_o, exp_esr);
      chk("R2 btr held", btr_o, exp_btr);
      chk("R2 link held", link_o, exp_link);
      chk("R2 pc pass", pc_o, 32'h7700 + 32'(c));
      chk("R2 msr pass", msr_o, 32'h0000_2800 | 32'(c));
      chk("R2 flags pass", {30'd0, dslot_o, imm_o}, {30'd0, 1'b1, c[0]});
    end
    raise_i = 1'b0; exc_en_i = 1'b1;

    // R11 raise while exception-in-progress already set
    raise_once(5, 1'b0, 1'b1, 32'h0000_2A00, 32'h4440, 32'h1234_5678);
    chk("R11 accepted esr", esr_o, 32'd5);
    raise_once(10, 1'b1, 1'b0, entry_msr(32'h0000_2A00), 32'h5550, 32'h2222_0000);
    chk("R11 overwrite link", link_o, 32'h5554);
    chk("R11 overwrite btr", btr_o, 32'h2222_0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule